// File: doc/BRIEF.md
# Serial Channel Driver Controller with Fault Readback

This block is the logic front end of an eight-channel switch controller. A host drives three serial lines: data, clock and an active-low enable. Each enable frame clocks a new control word into a shift register. When the enable returns high, the whole word moves into an output latch, and the latch drives the channel enables. A fourth line is open-drain and returns the register contents, so several controllers can share one enable and form a chain.

The analog side reports each channel through two synchronous flags: the output sits high, or the output sits low. A high flag on a channel that is switched on means a short. A low flag on a channel that is switched off means an open load. When the enable falls, the register bit of every faulty channel is inverted. The word read back during the next frame is therefore the last control word with the faulty channels flipped, and comparing it with what was written tells the host which channel failed and how. Two active-low summary pins flag any short and any open load. The short pin is blanked for a programmable number of clocks after every latch load so that switching transients do not show on it.

The serial lines are not related to the system clock. A two-flop synchronizer samples them, and the block acts on the edges it detects there.

Top module: `serdrv_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves all channel enables at 0, releases the serial output (`dout_oe`=0) and holds both status pins high while no flag is set.
- R2: While the synchronized enable is low, each high-to-low edge of `ser_clk` captures `ser_din` into the shift register. Bits are sent channel 0 first, so the bit captured last in a frame belongs to the highest channel. The effect appears on the third rising system-clock edge after the input changes.
- R3: `ch_on` changes only on a low-to-high edge of the enable. That edge copies the full register into the latch, and latch bit k = 1 turns channel k on.
- R4: During a frame the serial output presents the register bit of the oldest channel. The value is refreshed on each low-to-high edge of `ser_clk`. `dout_oe`=1 pulls the line low for a 0 bit, and `dout_oe`=0 leaves it high for a 1 bit.
- R5: While the enable is high, `ser_clk` and `ser_din` have no effect on the register or the latch, and `dout_oe` stays 0.
- R6: On the high-to-low edge of the enable, the register bit of every faulty channel is inverted. A channel is faulty when it is on with `hi_flag` set, or off with `lo_flag` set.
- R7: `short_n` is 0 when any channel that is on has its `hi_flag` set and no blanking window is open. Otherwise it is 1.
- R8: `open_n` is 0 when any channel that is off has its `lo_flag` set. Otherwise it is 1.
- R9: After each latch load, `short_n` is held at 1 for `BLANK_CYC` system clocks.
- R10: A full frame reads back, channel 0 first, the previous control word with the faulty channels flipped, which is the word a chained controller would receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_din | input | 1 | Serial data in, asynchronous |
| ser_en_n | input | 1 | Active-low frame enable, asynchronous |
| hi_flag | input | N | Per-channel flag: the output sits high |
| lo_flag | input | N | Per-channel flag: the output sits low |
| ch_on | output | N | Channel enables from the latch |
| dout_oe | output | 1 | Open-drain pull-low enable for the serial output |
| short_n | output | 1 | Active-low summary of shorts |
| open_n | output | 1 | Active-low summary of open loads |

## Verification
The bench writes words and reads them back under several fault mixes. It checks that the readback has exactly the faulty channels flipped. A design that inverted bits on the rising enable edge, or that reversed the channel order, would return a different word. It toggles the serial clock and data while the enable is high. A design that did not gate those lines would corrupt the next readback or move `ch_on`. It holds a short on an enabled channel across a latch load and checks that `short_n` stays high through the window and then falls. A counter that did not reload, or that ran off by one, shows up in the cycle-by-cycle comparison with the model.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // Edge information for one synchronized serial line
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    // The single action taken by the serial engine in a given cycle
    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_LOAD    = 3'd1,
        EV_ARM     = 3'd2,
        EV_SHIFT   = 3'd3,
        EV_PRESENT = 3'd4
    } sev_t;

    // Enable edges win over clock edges; clock edges only count inside a frame
    function automatic sev_t pick_event(edge_t en_n, edge_t ck);
        if (en_n.rise)
            return EV_LOAD;
        else if (en_n.fall)
            return EV_ARM;
        else if (!en_n.level && ck.fall)
            return EV_SHIFT;
        else if (!en_n.level && ck.rise)
            return EV_PRESENT;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/sdc_sync.sv
module sdc_sync
    import sdc_pkg::*;
#(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t ev
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {STAGES{IDLE}};
            prev <= IDLE;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign ev.level = pipe[STAGES-1];
    assign ev.rise  = pipe[STAGES-1] & ~prev;
    assign ev.fall  = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/sdc_shift.sv
module sdc_shift
    import sdc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sev_t         ev,
    input  logic         din,
    input  logic [N-1:0] fault_mask,
    output logic [N-1:0] sr_q,
    output logic [N-1:0] latch_q,
    output logic         active_q,
    output logic         so_q
);
    // The register fills from bit 0 upward, so channel k lives at bit N-1-k
    logic [N-1:0] fault_rev;
    logic [N-1:0] sr_rev;
    logic [N-1:0] sr_armed;

    for (genvar i = 0; i < N; i++) begin : g_rev
        assign fault_rev[N-1-i] = fault_mask[i];
        assign sr_rev[i]        = sr_q[N-1-i];
    end

    assign sr_armed = sr_q ^ fault_rev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q     <= '0;
            latch_q  <= '0;
            active_q <= 1'b0;
            so_q     <= 1'b1;
        end else begin
            unique case (ev)
                EV_LOAD: begin
                    latch_q  <= sr_rev;
                    active_q <= 1'b0;
                    so_q     <= 1'b1;
                end
                EV_ARM: begin
                    sr_q     <= sr_armed;
                    active_q <= 1'b1;
                    so_q     <= sr_armed[N-1];
                end
                EV_SHIFT:   sr_q <= {sr_q[N-2:0], din};
                EV_PRESENT: so_q <= sr_q[N-1];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdc_diag.sv
module sdc_diag #(
    parameter int N         = 8,
    parameter int BLANK_CYC = 16,
    localparam int CW       = $clog2(BLANK_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [N-1:0]  ch_on,
    input  logic [N-1:0]  hi_flag,
    input  logic [N-1:0]  lo_flag,
    output logic [N-1:0]  fault_mask,
    output logic [CW-1:0] blank_cnt,
    output logic          short_n,
    output logic          open_n
);
    localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC);

    logic [N-1:0] shorts;
    logic [N-1:0] opens;

    assign shorts     = ch_on & hi_flag;
    assign opens      = ~ch_on & lo_flag;
    assign fault_mask = shorts | opens;

    always_ff @(posedge clk) begin
        if (rst)
            blank_cnt <= '0;
        else if (load)
            blank_cnt <= BLANK_LD;
        else if (blank_cnt != '0)
            blank_cnt <= blank_cnt - 1'b1;
    end

    assign short_n = ~((|shorts) && (blank_cnt == '0));
    assign open_n  = ~(|opens);
endmodule

// File: rtl/serdrv_ctrl.sv
module serdrv_ctrl
    import sdc_pkg::*;
#(
    parameter int N         = 8,
    parameter int BLANK_CYC = 16,
    parameter int SYNC_STG  = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk,
    input  logic         ser_din,
    input  logic         ser_en_n,
    input  logic [N-1:0] hi_flag,
    input  logic [N-1:0] lo_flag,
    output logic [N-1:0] ch_on,
    output logic         dout_oe,
    output logic         short_n,
    output logic         open_n
);
    localparam int           NLINE  = 3;
    localparam int           CW     = $clog2(BLANK_CYC + 1);
    localparam logic [2:0]   IDLE_V = 3'b100;   // {enable, clock, data}

    logic [NLINE-1:0] raw;
    edge_t            ev_arr [NLINE];
    sev_t             ev_cur;
    logic [N-1:0]     sr_q;
    logic [N-1:0]     fault_mask;
    logic [CW-1:0]    blank_cnt;
    logic             active_q;
    logic             so_q;
    logic             din_lvl;
    logic [1:0]       din_edges_unused;

    assign raw = {ser_en_n, ser_clk, ser_din};

    for (genvar i = 0; i < NLINE; i++) begin : g_sync
        sdc_sync #(.STAGES(SYNC_STG), .IDLE(IDLE_V[i])) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[i]),
            .ev  (ev_arr[i])
        );
    end

    assign din_lvl          = ev_arr[0].level;
    assign din_edges_unused = {ev_arr[0].rise, ev_arr[0].fall};
    assign ev_cur           = pick_event(ev_arr[2], ev_arr[1]);

    sdc_shift #(.N(N)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev_cur),
        .din        (din_lvl),
        .fault_mask (fault_mask),
        .sr_q       (sr_q),
        .latch_q    (ch_on),
        .active_q   (active_q),
        .so_q       (so_q)
    );

    sdc_diag #(.N(N), .BLANK_CYC(BLANK_CYC)) u_diag (
        .clk        (clk),
        .rst        (rst),
        .load       (ev_cur == EV_LOAD),
        .ch_on      (ch_on),
        .hi_flag    (hi_flag),
        .lo_flag    (lo_flag),
        .fault_mask (fault_mask),
        .blank_cnt  (blank_cnt),
        .short_n    (short_n),
        .open_n     (open_n)
    );

    assign dout_oe = active_q & ~so_q;
endmodule

// File: rtl/serdrv_ctrl_chk.sv
module serdrv_ctrl_chk
    import sdc_pkg::*;
#(
    parameter int N         = 8,
    parameter int BLANK_CYC = 16,
    localparam int CW       = $clog2(BLANK_CYC + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          ser_en_n,
    input logic [N-1:0]  ch_on,
    input logic          dout_oe,
    input logic          short_n,
    input sev_t          ev_cur,
    input logic          din_lvl,
    input logic [N-1:0]  sr_q,
    input logic [CW-1:0] blank_cnt
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ch_on == '0 && !dout_oe));

    a_r2_shift_capture: assert property (@(posedge clk) disable iff (rst)
        (ev_cur == EV_SHIFT) |=> (sr_q[0] == $past(din_lvl)));

    a_r3_latch_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_on) |-> ($past(ev_cur) == EV_LOAD));

    a_r5_released_when_idle: assert property (@(posedge clk) disable iff (rst)
        (ser_en_n && $past(ser_en_n) && $past(ser_en_n, 2) && $past(ser_en_n, 3))
            |-> !dout_oe);

    a_r9_blank_reload: assert property (@(posedge clk) disable iff (rst)
        (ev_cur == EV_LOAD) |=> (blank_cnt == CW'(BLANK_CYC)));

    a_r7_blank_hides_short: assert property (@(posedge clk) disable iff (rst)
        (blank_cnt != '0) |-> short_n);
endmodule

bind serdrv_ctrl serdrv_ctrl_chk #(.N(N), .BLANK_CYC(BLANK_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_en_n  (ser_en_n),
    .ch_on     (ch_on),
    .dout_oe   (dout_oe),
    .short_n   (short_n),
    .ev_cur    (ev_cur),
    .din_lvl   (din_lvl),
    .sr_q      (sr_q),
    .blank_cnt (blank_cnt)
);

// File: tb/tb_serdrv_ctrl.sv
module tb_serdrv_ctrl;
    localparam int N     = 8;
    localparam int BLANK = 16;
    localparam int H     = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_din = 1'b0;
    logic         ser_en_n = 1'b1;
    logic [N-1:0] hi_flag = '0;
    logic [N-1:0] lo_flag = '0;
    logic [N-1:0] ch_on;
    logic         dout_oe;
    logic         short_n;
    logic         open_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    serdrv_ctrl #(.N(N), .BLANK_CYC(BLANK)) dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_en_n(ser_en_n), .hi_flag(hi_flag), .lo_flag(lo_flag),
        .ch_on(ch_on), .dout_oe(dout_oe), .short_n(short_n), .open_n(open_n)
    );

    // Behavioural reference: input history queues, channel-ordered word
    logic   qen[$];
    logic   qck[$];
    logic   qdi[$];
    logic   m_word [N];
    logic   m_lat  [N];
    logic   m_act;
    logic   m_out;
    int     m_blank;

    function automatic logic [N-1:0] m_lat_vec();
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = m_lat[k];
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            qen = {1'b1, 1'b1, 1'b1, 1'b1};
            qck = {1'b0, 1'b0, 1'b0, 1'b0};
            qdi = {1'b0, 1'b0, 1'b0, 1'b0};
            for (int k = 0; k < N; k++) begin m_word[k] = 0; m_lat[k] = 0; end
            m_act = 0; m_out = 1; m_blank = 0;
        end else begin
            logic [N-1:0] lv;
            qen.push_front(ser_en_n); qen = qen[0:3];
            qck.push_front(ser_clk);  qck = qck[0:3];
            qdi.push_front(ser_din);  qdi = qdi[0:3];
            lv = m_lat_vec();
            if (m_blank > 0) m_blank--;
            if (!qen[3] && qen[2]) begin
                for (int k = 0; k < N; k++) m_lat[k] = m_word[k];
                m_act = 0; m_out = 1; m_blank = BLANK;
            end else if (qen[3] && !qen[2]) begin
                for (int k = 0; k < N; k++)
                    if ((lv[k] && hi_flag[k]) || (!lv[k] && lo_flag[k]))
                        m_word[k] = !m_word[k];
                m_act = 1; m_out = m_word[0];
            end else if (!qen[2] && qck[3] && !qck[2]) begin
                for (int k = 0; k < N-1; k++) m_word[k] = m_word[k+1];
                m_word[N-1] = qdi[2];
            end else if (!qen[2] && !qck[3] && qck[2]) begin
                m_out = m_word[0];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [N-1:0] lv;
            logic e_oe, e_sn, e_on;
            lv   = m_lat_vec();
            e_oe = m_act && !m_out;
            e_sn = !((|(lv & hi_flag)) && m_blank == 0);
            e_on = !(|(~lv & lo_flag));
            chk(ch_on == lv,     "R3 latch", 32'(ch_on), 32'(lv));
            chk(dout_oe == e_oe, "R4 serial out", 32'(dout_oe), 32'(e_oe));
            chk(short_n == e_sn, "R7/R9 short status", 32'(short_n), 32'(e_sn));
            chk(open_n == e_on,  "R8 open status", 32'(open_n), 32'(e_on));
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full frame: write w (channel 0 first), return the word read back
    task automatic xfer(input logic [N-1:0] w, output logic [N-1:0] r);
        ser_en_n = 1'b0;
        wait_neg(H);
        for (int k = 0; k < N; k++) begin
            ser_din = w[k];
            ser_clk = 1'b1;
            wait_neg(H);
            r[k] = ~dout_oe;
            ser_clk = 1'b0;
            wait_neg(H);
        end
        ser_en_n = 1'b1;
        wait_neg(H);
    endtask

    initial begin
        logic [N-1:0] rd;
        wait_neg(5);
        rst = 1'b0;
        wait_neg(2);
        chk(ch_on == '0, "R1 channels off", 32'(ch_on), 0);
        chk(dout_oe == 0 && short_n && open_n, "R1 pins idle",
            {29'd0, dout_oe, short_n, open_n}, 3'b011);

        xfer(8'hA5, rd);
        chk(rd == 8'h00, "R10 first readback", 32'(rd), 0);
        chk(ch_on == 8'hA5, "R2 word written", 32'(ch_on), 32'hA5);

        lo_flag = 8'h02;           // channel 1 is off -> open
        wait_neg(2);
        chk(open_n == 0, "R8 open seen", 32'(open_n), 0);
        xfer(8'h3C, rd);
        chk(rd == (8'hA5 ^ 8'h02), "R6 open flips bit", 32'(rd), 32'(8'hA5 ^ 8'h02));

        hi_flag = 8'h04;           // channel 2 is on in 0x3C -> short
        xfer(8'h3C, rd);
        chk(short_n == 1, "R9 short blanked", 32'(short_n), 1);
        wait_neg(BLANK + 2);
        chk(short_n == 0, "R7 short after blank", 32'(short_n), 0);
        xfer(8'h81, rd);
        chk(rd == (8'h3C ^ 8'h06), "R6 short and open flip", 32'(rd), 32'(8'h3C ^ 8'h06));

        hi_flag = '0; lo_flag = '0;
        wait_neg(2);
        for (int t = 0; t < 10; t++) begin
            ser_din = t[0]; ser_clk = ~ser_clk;
            wait_neg(H);
            chk(dout_oe == 0, "R5 output released", 32'(dout_oe), 0);
        end
        ser_clk = 1'b0;
        wait_neg(H);
        chk(ch_on == 8'h81, "R5 latch kept", 32'(ch_on), 32'h81);
        xfer(8'hFF, rd);
        chk(rd == 8'h81, "R5 register kept / R10 chain word", 32'(rd), 32'h81);
        xfer(8'h00, rd);
        chk(rd == 8'hFF, "R10 all ones back", 32'(rd), 32'hFF);
        chk(ch_on == 8'h00, "R3 all off", 32'(ch_on), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule